// File: doc/BRIEF.md
# Programmable-Format Asynchronous Serial Transceiver

A full-duplex asynchronous serial port that runs from the system clock. Software programs the frame format through a small byte-wide register interface. The data length is 5 to 8 bits. There can be one or two stop bits. Parity can be none, even or odd. A complete frame is therefore 7 to 12 bits long, counting the start bit. The bit rate comes from a 16-bit divisor, written as a low byte and a high byte. One bit lasts 16 × divisor system clocks.

Each direction has one holding register in front of its shift register. Software can queue the next transmit word while the current one is still on the line. A received word waits in its holding register, together with its parity-error and framing-error flags, while the next frame is shifted in. The receive and transmit interrupts each have their own mask bit.

Register map (3-bit address). Reads have no side effect except where noted.

| Address | Write | Read |
|---|---|---|
| 0 | transmit word | received word (also clears the receive-ready flag) |
| 1 | format: [1:0] length code (length = 5 + code), [2] two stop bits, [4:3] parity (0 none, 1 even, 2 odd, 3 none) | format |
| 2 | divisor low byte | divisor low byte |
| 3 | divisor high byte | divisor high byte |
| 4 | interrupt mask: [0] receive, [1] transmit | mask |
| 5 | no effect | status (also clears overrun): [0] receive ready, [1] overrun, [2] parity error, [3] framing error, [4] transmit holding empty, [5] transmitter idle |

Top module: `uart_fmt_top`

## Requirements
- R1: After reset, txd is high, both interrupts are low and status reads 0x30: transmit holding empty, transmitter idle, no received word and no error.
- R2: A transmitted frame is one low start bit, then the data bits least significant bit first, with the count set by the length code (5 to 8). Between frames the line stays high.
- R3: A transmitted frame ends with one or two high stop bits, as selected by format bit 2. A queued word starts only after those stop bits.
- R4: With even parity, the parity bit follows the data and makes the number of ones in data plus parity even. With odd parity it makes that number odd. With parity codes 0 and 3 no parity bit is sent.
- R5: One bit lasts 16 × D system clocks, where D = {high byte, low byte} and reset sets D to 1. A divisor of 0 acts as 1.
- R6: When the shifter takes the held word, status bit 4 sets within a few cycles. A second word written while the first is on the line is sent right after the first. A write to address 0 while the holding register is full is ignored.
- R7: The receiver looks for a falling edge on rxd, checks at mid-bit that the start bit is still low, and samples each later bit at its mid-point. A complete word sets status bit 0. The word reads back at address 0, and that read clears bit 0.
- R8: A word that completes while the receive holding register is full is discarded and sets status bit 1. The held word is unchanged. A status read clears bit 1.
- R9: If the first stop-bit sample is low, status bit 3 is set together with the received word.
- R10: If the received parity does not match the programmed mode, status bit 2 is set together with the received word.
- R11: irq_rx is high exactly when a received word is waiting and mask bit 0 is set. irq_tx is high exactly when the transmit holding register is empty and mask bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register write address |
| wr_data | input | 8 | register write data |
| rd_en | input | 1 | register read strobe (triggers the read side effects) |
| rd_addr | input | 3 | register read address |
| rd_data | output | 8 | register read data, combinational from rd_addr |
| rxd | input | 1 | serial receive line |
| txd | output | 1 | serial transmit line |
| irq_rx | output | 1 | masked receive interrupt |
| irq_tx | output | 1 | masked transmit interrupt |

## Verification
Transmit frames are decoded in the bench by a behavioural line sampler that knows the programmed divisor. The formats used are 8N1, 5E2 (with two words queued back to back), 7O1, and a 5-bit frame at a divisor whose high byte is nonzero. Wrong bit ordering, a missing or inverted parity bit, a wrong stop count and ignoring the divisor high byte each give a different mismatch. Receive frames are driven with good parity, odd parity, a flipped parity bit, a low stop bit and two unread frames in a row. These separate clean reception from the parity, framing and overrun flags. Mask toggling shows that the interrupts follow the flags only when enabled.

// File: rtl/uart_fmt_pkg.sv
package uart_fmt_pkg;

    localparam int unsigned MAX_DATA = 8;
    localparam int unsigned OVS      = 16;
    localparam int unsigned OVS_W    = $clog2(OVS);
    localparam int unsigned IDX_W    = $clog2(MAX_DATA);

    localparam logic [2:0] A_DATA   = 3'd0;
    localparam logic [2:0] A_FMT    = 3'd1;
    localparam logic [2:0] A_DIVL   = 3'd2;
    localparam logic [2:0] A_DIVH   = 3'd3;
    localparam logic [2:0] A_MASK   = 3'd4;
    localparam logic [2:0] A_STATUS = 3'd5;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_NONE3 = 2'd3
    } par_mode_t;

    typedef struct packed {
        par_mode_t  par;
        logic       two_stop;
        logic [1:0] len_code;
    } frame_cfg_t;

    typedef struct packed {
        logic [MAX_DATA-1:0] data;
        logic                perr;
        logic                ferr;
    } rx_word_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP
    } phase_t;

    function automatic logic [IDX_W-1:0] last_idx(input logic [1:0] code);
        return IDX_W'(4) + IDX_W'(code);
    endfunction

    function automatic logic has_par(input par_mode_t p);
        return (p == PAR_EVEN) || (p == PAR_ODD);
    endfunction

    function automatic logic par_of(input logic [MAX_DATA-1:0] d,
                                    input logic [1:0] code,
                                    input logic odd);
        logic [MAX_DATA-1:0] m;
        m = {MAX_DATA{1'b1}} >> (2'd3 - code);
        return (^(d & m)) ^ odd;
    endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim = (divisor == '0) ? DIV_W'(1) : divisor;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= lim - DIV_W'(1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + DIV_W'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser
    import uart_fmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  frame_cfg_t          cfg,
    input  logic                load_valid,
    input  logic [MAX_DATA-1:0] load_data,
    output logic                load_take,
    output logic                txd,
    output logic                busy
);
    phase_t              ph;
    logic [OVS_W-1:0]    cnt;
    logic [IDX_W-1:0]    idx;
    logic [MAX_DATA-1:0] sh;
    logic                par_q;
    logic                stop2;
    frame_cfg_t          cq;

    assign load_take = (ph == PH_IDLE) && load_valid;
    assign busy      = (ph != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_IDLE; cnt <= '0; idx <= '0; sh <= '0;
            par_q <= 1'b0; stop2 <= 1'b0; cq <= '0; txd <= 1'b1;
        end else if (ph == PH_IDLE) begin
            txd <= 1'b1;
            if (load_valid) begin
                sh    <= load_data;
                cq    <= cfg;
                par_q <= par_of(load_data, cfg.len_code, cfg.par == PAR_ODD);
                cnt   <= '0;
                ph    <= PH_START;
                txd   <= 1'b0;
            end
        end else if (tick) begin
            if (cnt != OVS_W'(OVS - 1)) begin
                cnt <= cnt + OVS_W'(1);
            end else begin
                cnt <= '0;
                unique case (ph)
                    PH_START: begin
                        ph  <= PH_DATA;
                        idx <= '0;
                        txd <= sh[0];
                    end
                    PH_DATA: begin
                        if (idx == last_idx(cq.len_code)) begin
                            stop2 <= 1'b0;
                            if (has_par(cq.par)) begin
                                ph  <= PH_PAR;
                                txd <= par_q;
                            end else begin
                                ph  <= PH_STOP;
                                txd <= 1'b1;
                            end
                        end else begin
                            idx <= idx + IDX_W'(1);
                            sh  <= sh >> 1;
                            txd <= sh[1];
                        end
                    end
                    PH_PAR: begin
                        ph  <= PH_STOP;
                        txd <= 1'b1;
                    end
                    PH_STOP: begin
                        if (cq.two_stop && !stop2) stop2 <= 1'b1;
                        else                       ph    <= PH_IDLE;
                    end
                    default: ph <= PH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
    import uart_fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    input  frame_cfg_t cfg,
    output logic       word_valid,
    output rx_word_t   word
);
    phase_t              ph;
    logic [OVS_W-1:0]    cnt;
    logic [IDX_W-1:0]    idx;
    logic [MAX_DATA-1:0] sh;
    logic                prev;
    logic                pacc;
    logic                perr_q;
    frame_cfg_t          cq;

    always_ff @(posedge clk) begin
        word_valid <= 1'b0;
        if (rst) begin
            ph <= PH_IDLE; cnt <= '0; idx <= '0; sh <= '0; prev <= 1'b1;
            pacc <= 1'b0; perr_q <= 1'b0; cq <= '0; word <= '0;
        end else if (tick) begin
            prev <= line;
            unique case (ph)
                PH_IDLE: begin
                    if (prev && !line) begin
                        ph  <= PH_START;
                        cnt <= '0;
                        cq  <= cfg;
                    end
                end
                PH_START: begin
                    if (cnt == OVS_W'(OVS / 2 - 1)) begin
                        cnt <= '0;
                        if (!line) begin
                            ph <= PH_DATA; idx <= '0; sh <= '0;
                            pacc <= 1'b0; perr_q <= 1'b0;
                        end else begin
                            ph <= PH_IDLE;
                        end
                    end else cnt <= cnt + OVS_W'(1);
                end
                PH_DATA: begin
                    if (cnt == OVS_W'(OVS - 1)) begin
                        cnt      <= '0;
                        sh[idx]  <= line;
                        pacc     <= pacc ^ line;
                        if (idx == last_idx(cq.len_code))
                            ph <= has_par(cq.par) ? PH_PAR : PH_STOP;
                        else
                            idx <= idx + IDX_W'(1);
                    end else cnt <= cnt + OVS_W'(1);
                end
                PH_PAR: begin
                    if (cnt == OVS_W'(OVS - 1)) begin
                        cnt    <= '0;
                        perr_q <= pacc ^ line ^ (cq.par == PAR_ODD);
                        ph     <= PH_STOP;
                    end else cnt <= cnt + OVS_W'(1);
                end
                PH_STOP: begin
                    if (cnt == OVS_W'(OVS - 1)) begin
                        cnt        <= '0;
                        word       <= '{data: sh, perr: perr_q, ferr: !line};
                        word_valid <= 1'b1;
                        ph         <= PH_IDLE;
                    end else cnt <= cnt + OVS_W'(1);
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_fmt_top.sv
module uart_fmt_top
    import uart_fmt_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       rxd,
    output logic       txd,
    output logic       irq_rx,
    output logic       irq_tx
);
    localparam int unsigned HALF = DIV_W / 2;

    frame_cfg_t          cfg_q;
    logic [HALF-1:0]     div_lo, div_hi;
    logic [1:0]          mask_q;
    logic [MAX_DATA-1:0] thr_data;
    logic                thr_full;
    rx_word_t            rx_hold;
    logic                rx_full;
    logic                overrun;
    logic [1:0]          rx_sync;
    logic                baud_tick;
    logic                tx_take, tx_busy;
    logic                rx_valid;
    rx_word_t            rx_word;
    logic [DIV_W-1:0]    divisor;
    logic                rd_data_now, rd_stat_now;

    assign divisor     = {div_hi, div_lo};
    assign rd_data_now = rd_en && (rd_addr == A_DATA);
    assign rd_stat_now = rd_en && (rd_addr == A_STATUS);

    uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .divisor(divisor), .tick(baud_tick)
    );

    uart_tx_ser u_tx (
        .clk(clk), .rst(rst), .tick(baud_tick), .cfg(cfg_q),
        .load_valid(thr_full), .load_data(thr_data), .load_take(tx_take),
        .txd(txd), .busy(tx_busy)
    );

    uart_rx_deser u_rx (
        .clk(clk), .rst(rst), .tick(baud_tick), .line(rx_sync[1]),
        .cfg(cfg_q), .word_valid(rx_valid), .word(rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0; div_lo <= HALF'(1); div_hi <= '0; mask_q <= '0;
            thr_data <= '0; thr_full <= 1'b0;
            rx_hold <= '0; rx_full <= 1'b0; overrun <= 1'b0;
            rx_sync <= 2'b11;
        end else begin
            rx_sync <= {rx_sync[0], rxd};
            if (tx_take) thr_full <= 1'b0;
            if (wr_en) begin
                unique case (wr_addr)
                    A_DATA: if (!thr_full) begin
                        thr_data <= wr_data;
                        thr_full <= 1'b1;
                    end
                    A_FMT:  cfg_q  <= frame_cfg_t'(wr_data[4:0]);
                    A_DIVL: div_lo <= wr_data;
                    A_DIVH: div_hi <= wr_data;
                    A_MASK: mask_q <= wr_data[1:0];
                    default: ;
                endcase
            end
            if (rd_data_now) rx_full <= 1'b0;
            if (rd_stat_now) overrun <= 1'b0;
            if (rx_valid) begin
                if (rx_full) begin
                    overrun <= 1'b1;
                end else begin
                    rx_hold <= rx_word;
                    rx_full <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_DATA:   rd_data = rx_hold.data;
            A_FMT:    rd_data = {3'b000, cfg_q};
            A_DIVL:   rd_data = div_lo;
            A_DIVH:   rd_data = div_hi;
            A_MASK:   rd_data = {6'b0, mask_q};
            A_STATUS: rd_data = {2'b00, !thr_full && !tx_busy, !thr_full,
                                 rx_full && rx_hold.ferr, rx_full && rx_hold.perr,
                                 overrun, rx_full};
            default:  rd_data = '0;
        endcase
    end

    assign irq_rx = rx_full && mask_q[0];
    assign irq_tx = !thr_full && mask_q[1];
endmodule

// File: rtl/uart_fmt_chk.sv
module uart_fmt_chk (
    input logic        clk,
    input logic        rst,
    input logic        txd,
    input logic        tx_busy,
    input logic        thr_full,
    input logic        baud_tick,
    input logic [15:0] divisor,
    input logic        rx_full,
    input logic        rd_en,
    input logic [2:0]  rd_addr,
    input logic [7:0]  rx_data,
    input logic        overrun,
    input logic        irq_rx
);
    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> !txd);

    assert_tick_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (baud_tick && divisor > 16'd1 && $stable(divisor)) |=> !baud_tick);

    assert_thr_handoff_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(thr_full) |-> tx_busy);

    assert_rx_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !(rd_en && rd_addr == 3'd0)) |=> rx_full);

    assert_overrun_discard_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $stable(rx_data));

    assert_irq_rx_R11: assert property (@(posedge clk) disable iff (rst)
        irq_rx |-> rx_full);
endmodule

bind uart_fmt_top uart_fmt_chk u_chk (
    .clk(clk), .rst(rst), .txd(txd), .tx_busy(tx_busy), .thr_full(thr_full),
    .baud_tick(baud_tick), .divisor(divisor), .rx_full(rx_full),
    .rd_en(rd_en), .rd_addr(rd_addr), .rx_data(rx_hold.data),
    .overrun(overrun), .irq_rx(irq_rx)
);

// File: tb/tb_uart_fmt_top.sv
`timescale 1ns/1ps
module tb_uart_fmt_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       rxd = 1'b1;
    logic       txd, irq_rx, irq_tx;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int div_now = 1;
    bit quiet = 1'b0;
    bit done = 1'b0;

    uart_fmt_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rxd(rxd),
        .txd(txd), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // line model compared every clock: with nothing queued the line must idle high
    always @(negedge clk) begin
        if (quiet && !rst && txd !== 1'b1) begin
            errors++;
            $display("FAIL R2 idle line at cycle %0d actual %b expected 1", cyc, txd);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #0.1 d = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_div(input int d);
        wr(3'd2, 8'(d));
        wr(3'd3, 8'(d >> 8));
        div_now = d;
    endtask

    function automatic logic exp_par(input logic [7:0] d, input int len, input int pm);
        logic [7:0] m;
        m = 8'hFF >> (8 - len);
        return (^(d & m)) ^ (pm == 2);
    endfunction

    task automatic cap(input int len, input int pm, input int stops,
                       output logic [7:0] d, output logic pb,
                       output bit ok, output int tf);
        bit s1, s2;
        while (txd !== 1'b0) @(negedge clk);
        tf = cyc;
        repeat (8 * div_now) @(negedge clk);
        ok = (txd === 1'b0);
        d = '0; pb = 1'b0; s2 = 1'b1;
        for (int i = 0; i < len; i++) begin
            repeat (16 * div_now) @(negedge clk);
            d[i] = txd;
        end
        if (pm == 1 || pm == 2) begin
            repeat (16 * div_now) @(negedge clk);
            pb = txd;
        end
        repeat (16 * div_now) @(negedge clk);
        s1 = txd;
        if (stops == 2) begin
            repeat (16 * div_now) @(negedge clk);
            s2 = txd;
        end
        ok = ok && s1 && s2;
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (16 * div_now) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int len, input int pm,
                        input bit flip, input bit bad_stop);
        drive_bit(1'b0);
        for (int i = 0; i < len; i++) drive_bit(d[i]);
        if (pm == 1 || pm == 2) drive_bit(exp_par(d, len, pm) ^ flip);
        drive_bit(!bad_stop);
        drive_bit(1'b1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] v, da, db;
        logic pa, pbb;
        bit oka, okb;
        int ta, tb;
        int waited;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        quiet = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd", txd, 1);
        chk("R1 irq", {irq_rx, irq_tx}, 0);
        rd(3'd5, v); chk("R1 status", v, 8'h30);

        // R5 divisor from both bytes: 0x0102, 5N1
        set_div(16'h0102);
        rd(3'd3, v); chk("R5 divisor high byte", v, 8'h01);
        wr(3'd1, 8'h00);
        quiet = 1'b0;
        wr(3'd0, 8'h16);
        cap(5, 0, 1, da, pa, oka, ta);
        chk("R5 slow frame data", da, 8'h16);
        chk("R5 slow frame framing", oka, 1);
        repeat (20 * div_now) @(negedge clk);

        // R2 8N1 at divisor 3
        set_div(3);
        wr(3'd1, 8'h03);
        wr(3'd0, 8'hA5);
        cap(8, 0, 1, da, pa, oka, ta);
        chk("R2 8N1 data lsb first", da, 8'hA5);
        chk("R2 8N1 start/stop", oka, 1);
        repeat (40) @(negedge clk);

        // R3 R4 R6: 5E2, two words queued
        wr(3'd1, 8'h0C);
        fork
            begin
                cap(5, 1, 2, da, pa, oka, ta);
                cap(5, 1, 2, db, pbb, okb, tb);
            end
            begin
                wr(3'd0, 8'h13);
                waited = 0;
                v = 0;
                while (!v[4] && waited < 10) begin
                    rd(3'd5, v);
                    waited++;
                end
                chk("R6 holding empties after handoff", v[4], 1);
                wr(3'd0, 8'h0C);
                rd(3'd5, v);
                chk("R6 holding full while first on line", v[4], 0);
                wr(3'd0, 8'hFF);  // ignored: holding already full
            end
        join
        chk("R2 first word 5 bits", da, 8'h13);
        chk("R4 even parity first", pa, exp_par(8'h13, 5, 1));
        chk("R3 two stops first", oka, 1);
        chk("R6 second word", db, 8'h0C);
        chk("R4 even parity second", pbb, exp_par(8'h0C, 5, 1));
        chk("R3 two stops second", okb, 1);
        chk("R3 spacing within tolerance",
            ((tb - ta) >= 9 * 48 - 4 && (tb - ta) <= 9 * 48 + 6), 1);
        repeat (200) @(negedge clk);
        rd(3'd5, v);
        chk("R6 ignored write sent nothing", v[5:4], 2'b11);

        // R4 7O1
        wr(3'd1, 8'h12);
        wr(3'd0, 8'h55);
        cap(7, 2, 1, da, pa, oka, ta);
        chk("R4 7O1 data", da, 8'h55);
        chk("R4 odd parity bit", pa, exp_par(8'h55, 7, 2));
        repeat (40) @(negedge clk);
        quiet = 1'b1;

        // R7 R11 receive 8N1
        wr(3'd1, 8'h03);
        wr(3'd4, 8'h01);
        send(8'h3C, 8, 0, 0, 0);
        rd(3'd5, v); chk("R7 status ready", v, 8'h31);
        chk("R11 irq_rx raised", irq_rx, 1);
        rd(3'd0, v); chk("R7 received data", v, 8'h3C);
        @(negedge clk);
        chk("R7 read clears ready", irq_rx, 0);
        rd(3'd5, v); chk("R7 status after read", v, 8'h30);

        // R7 odd parity good, 7 bits
        wr(3'd1, 8'h12);
        send(8'h5B, 7, 2, 0, 0);
        rd(3'd5, v); chk("R7 7O1 no error", v, 8'h31);
        rd(3'd0, v); chk("R7 7O1 data", v, 8'h5B);

        // R10 parity error, 6E1
        wr(3'd1, 8'h09);
        send(8'h2A, 6, 1, 1, 0);
        rd(3'd5, v); chk("R10 parity error flag", v, 8'h35);
        rd(3'd0, v); chk("R10 data kept", v, 8'h2A);

        // R9 framing error, 8N1
        wr(3'd1, 8'h03);
        send(8'h81, 8, 0, 0, 1);
        rd(3'd5, v); chk("R9 framing error flag", v, 8'h39);
        rd(3'd0, v); chk("R9 data kept", v, 8'h81);

        // R8 overrun
        send(8'h11, 8, 0, 0, 0);
        send(8'h22, 8, 0, 0, 0);
        rd(3'd5, v); chk("R8 overrun flag", v, 8'h33);
        rd(3'd0, v); chk("R8 first word kept", v, 8'h11);
        rd(3'd5, v); chk("R8 overrun cleared by status read", v, 8'h30);

        // R11 transmit interrupt mask
        wr(3'd4, 8'h02);
        @(negedge clk);
        chk("R11 irq_tx enabled", {irq_tx, irq_rx}, 2'b10);
        wr(3'd4, 8'h00);
        @(negedge clk);
        chk("R11 irq_tx masked", irq_tx, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule